// File: doc/BRIEF.md
# Memory-Mapped Serial Byte Transmitter

This block is a bus-attached serial transmitter. Software reaches it through an AXI4-Lite slave port with a 4-bit address and 32-bit data. It writes bytes into a 16-entry transmit queue and can empty that queue with a command word. The block drains the queue one byte at a time and sends each byte on a single output line as an asynchronous frame. The bit period is derived from the bus clock. With the defaults of a 110 MHz clock and 115200 baud, each bit lasts 955 clocks. Software reads a status word to learn whether the queue is empty or full.

The design holds three state machines:

- **Write machine.**
  - States: `BW_IDLE`, `BW_ACCEPT`, `BW_RESP`.
  - `BW_IDLE` goes to `BW_ACCEPT` once both address-valid and data-valid are high.
  - `BW_ACCEPT` goes to `BW_RESP` unconditionally. This is the one cycle in which both readies are raised and the register action takes effect.
  - `BW_RESP` goes back to `BW_IDLE` on response-ready.
- **Read machine.**
  - States: `BR_IDLE`, `BR_ACCEPT`, `BR_DATA`.
  - `BR_IDLE` goes to `BR_ACCEPT` on read-address-valid.
  - `BR_ACCEPT` goes to `BR_DATA` unconditionally. This is the one cycle in which read-address-ready is raised and the read word is captured.
  - `BR_DATA` goes back to `BR_IDLE` on read-ready.
- **Line driver.**
  - States: `LN_IDLE`, `LN_START`, `LN_DATA`, `LN_STOP`.
  - `LN_IDLE` goes to `LN_START` when the queue is not empty, popping the head byte.
  - `LN_START` goes to `LN_DATA` after one bit period.
  - `LN_DATA` stays for eight bit periods and then goes to `LN_STOP`.
  - `LN_STOP` goes back to `LN_IDLE` after one bit period.

Writes that arrive while the queue is full still receive a normal response, but their byte is discarded. A software loop that outpaces the line therefore loses data silently. It must poll the full flag to avoid this.

Top module: `lite_serial_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following hold after that edge: `tx` is 1, `awready`, `wready`, `bvalid`, `arready` and `rvalid` are 0, and the queue is empty. A status read after reset returns 0x4.
- R2: Each byte leaves as a frame on `tx`, least significant bit first: one 0 start bit, eight data bits, then one 1 stop bit. Each bit lasts DIV = round(CLK_HZ/BAUD) clocks, and the line rests at 1 between frames.
- R3: A write to address 0x4 with `wstrb[0]`=1 queues `wdata[7:0]`, and the upper data bits are ignored. The same write with `wstrb[0]`=0 queues nothing.
- R4: The queue holds DEPTH (default 16) bytes. Bytes are sent in the order they were accepted, and one byte may be on the line while DEPTH more wait.
- R5: A data write that arrives while the queue is full is dropped. Its response is still OKAY (`bresp`=00).
- R6: Address and data may arrive in either order, or together. `awready` and `wready` rise together for exactly one cycle, and only while both valids are high.
- R7: After the handshake, `bvalid` rises with `bresp`=00 and stays high until a cycle with `bready` high.
- R8: A read raises `arready` for one cycle. `rvalid` then rises with `rresp`=00 and stays high, with `rdata` unchanged, until `rready`.
- R9: A read of 0x8 returns status: bit 2 = queue empty, bit 3 = queue full, and all other bits 0.
- R10: A write to 0xC with `wdata[0]`=1 (and `wstrb[0]`=1) empties the queue in one cycle. A byte already on the line finishes its frame.
- R11: A write to 0xC with only `wdata[1]` set leaves the transmit queue unchanged. Command bits do not persist, so a read of 0xC returns 0.
- R12: A read of 0x0 returns 0. Writes to 0x0 or 0x8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bresp | output | 2 | Write response code, always 00 |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response taken |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code, always 00 |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data taken |
| tx | output | 1 | Serial output line, idle high |

## Verification
A bus push into the queue can land in the same cycle as the line driver popping the head. A queue flush can land while a byte is already leaving the line. The overflow scenario bursts twenty writes into an idle transmitter, so the first push is popped at once while later pushes meet a full queue. It is judged by the exact set of bytes that appear on the line (the first seventeen, in order) and by the status word reading full. The flush scenario issues the command while the first of five bytes is on the line. It is judged by that single frame completing intact, the status reading empty immediately afterwards, and a later byte still being accepted.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        BW_IDLE   = 2'd0,
        BW_ACCEPT = 2'd1,
        BW_RESP   = 2'd2
    } bw_state_t;

    typedef enum logic [1:0] {
        BR_IDLE   = 2'd0,
        BR_ACCEPT = 2'd1,
        BR_DATA   = 2'd2
    } br_state_t;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_DATA  = 2'd2,
        LN_STOP  = 2'd3
    } ln_state_t;

    localparam logic [3:0] OFS_RX_WORD = 4'h0;
    localparam logic [3:0] OFS_TX_BYTE = 4'h4;
    localparam logic [3:0] OFS_STATUS  = 4'h8;
    localparam logic [3:0] OFS_COMMAND = 4'hC;

    localparam int STAT_EMPTY_POS = 2;
    localparam int STAT_FULL_POS  = 3;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/lst_byte_fifo.sv
module lst_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             push_ok;
    logic             pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    // Fullness is judged before any pop of the same cycle.
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/lst_line_driver.sv
module lst_line_driver
    import sertx_pkg::*;
#(
    parameter int DIV = 955
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  logic [BYTE_W-1:0] q_head,
    output logic              pop,
    output logic              tx
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    ln_state_t         st_q;
    ln_state_t         st_d;
    logic [CW-1:0]     tick_cnt;
    logic [2:0]        bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              bit_end;

    assign bit_end = (tick_cnt == CW'(DIV - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LN_IDLE:  if (!q_empty)                 st_d = LN_START;
            LN_START: if (bit_end)                  st_d = LN_DATA;
            LN_DATA:  if (bit_end && bit_idx == 3'd7) st_d = LN_STOP;
            LN_STOP:  if (bit_end)                  st_d = LN_IDLE;
            default:                                st_d = LN_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pop = 1'b0;
        tx  = 1'b1;
        unique case (st_q)
            LN_IDLE:  pop = !q_empty;
            LN_START: tx  = 1'b0;
            LN_DATA:  tx  = shreg[0];
            LN_STOP:  tx  = 1'b1;
            default:  tx  = 1'b1;
        endcase
    end

    // Bit timing and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
        end else if (st_q == LN_IDLE) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            if (!q_empty) begin
                shreg <= q_head;
            end
        end else begin
            tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
            if (st_q == LN_DATA && bit_end) begin
                shreg   <= {1'b0, shreg[BYTE_W-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lst_bus_port.sv
module lst_bus_port
    import sertx_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              rready,
    input  logic              q_empty,
    input  logic              q_full,
    output logic              push,
    output logic [BYTE_W-1:0] push_byte,
    output logic              flush_tx
);
    localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(OFS_TX_BYTE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_COMMAND);

    bw_state_t         bw_q;
    bw_state_t         bw_d;
    br_state_t         br_q;
    br_state_t         br_d;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] stat_word;
    logic              bus_unused;

    // Upper data lanes and strobes carry nothing this block keeps.
    assign bus_unused = ^{wdata[DATA_W-1:BYTE_W], wstrb[STRB_W-1:1]};
    assign push_byte  = wdata[BYTE_W-1:0];

    always_comb begin
        stat_word                 = '0;
        stat_word[STAT_EMPTY_POS] = q_empty;
        stat_word[STAT_FULL_POS]  = q_full;
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bw_q <= BW_IDLE;
            br_q <= BR_IDLE;
        end else begin
            bw_q <= bw_d;
            br_q <= br_d;
        end
    end

    // Next state
    always_comb begin
        bw_d = bw_q;
        unique case (bw_q)
            BW_IDLE:   if (awvalid && wvalid) bw_d = BW_ACCEPT;
            BW_ACCEPT:                        bw_d = BW_RESP;
            BW_RESP:   if (bready)            bw_d = BW_IDLE;
            default:                          bw_d = BW_IDLE;
        endcase
        br_d = br_q;
        unique case (br_q)
            BR_IDLE:   if (arvalid) br_d = BR_ACCEPT;
            BR_ACCEPT:              br_d = BR_DATA;
            BR_DATA:   if (rready)  br_d = BR_IDLE;
            default:                br_d = BR_IDLE;
        endcase
    end

    // Outputs and register actions
    always_comb begin
        awready  = 1'b0;
        wready   = 1'b0;
        bvalid   = 1'b0;
        push     = 1'b0;
        flush_tx = 1'b0;
        unique case (bw_q)
            BW_IDLE: ;
            BW_ACCEPT: begin
                awready = 1'b1;
                wready  = 1'b1;
                if (wstrb[0]) begin
                    push     = (awaddr == A_TX);
                    flush_tx = (awaddr == A_CMD) && wdata[0];
                end
            end
            BW_RESP: bvalid = 1'b1;
            default: ;
        endcase
        arready = (br_q == BR_ACCEPT);
        rvalid  = (br_q == BR_DATA);
    end

    // Read word capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (br_q == BR_ACCEPT) begin
            rdata_q <= (araddr == A_STAT) ? stat_word : '0;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/lite_serial_tx.sv
module lite_serial_tx
    import sertx_pkg::*;
#(
    parameter int CLK_HZ = 110_000_000,
    parameter int BAUD   = 115_200,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic              tx
);
    localparam int DIV = (CLK_HZ + BAUD / 2) / BAUD;

    logic              push_req;
    logic              flush_tx;
    logic              pop;
    logic              fifo_empty;
    logic              fifo_full;
    logic [BYTE_W-1:0] push_byte;
    logic [BYTE_W-1:0] head_byte;

    assign bresp = 2'b00;
    assign rresp = 2'b00;

    lst_bus_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STRB_W (STRB_W)
    ) bus_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .awaddr    (awaddr),
        .awvalid   (awvalid),
        .awready   (awready),
        .wdata     (wdata),
        .wstrb     (wstrb),
        .wvalid    (wvalid),
        .wready    (wready),
        .bvalid    (bvalid),
        .bready    (bready),
        .araddr    (araddr),
        .arvalid   (arvalid),
        .arready   (arready),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .rready    (rready),
        .q_empty   (fifo_empty),
        .q_full    (fifo_full),
        .push      (push_req),
        .push_byte (push_byte),
        .flush_tx  (flush_tx)
    );

    lst_byte_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (BYTE_W)
    ) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_tx),
        .push  (push_req),
        .din   (push_byte),
        .pop   (pop),
        .dout  (head_byte),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    lst_line_driver #(
        .DIV (DIV)
    ) line_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_empty (fifo_empty),
        .q_head  (head_byte),
        .pop     (pop),
        .tx      (tx)
    );

endmodule

// File: rtl/lst_checker.sv
module lst_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              awvalid,
    input logic              wvalid,
    input logic              awready,
    input logic              wready,
    input logic              bvalid,
    input logic              bready,
    input logic              arready,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata,
    input logic              tx,
    input logic              fifo_empty,
    input logic              fifo_full,
    input logic              push_req,
    input logic              pop,
    input logic              flush_tx
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (tx && !bvalid && !rvalid && !awready && !wready && !arready && fifo_empty))
        else $error("R1 outputs not quiet after reset");

    a_r6_ready_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        awready |-> (awvalid && wvalid && wready))
        else $error("R6 ready raised without both valids");

    a_r6_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        awready |=> !awready)
        else $error("R6 ready held beyond one cycle");

    a_r7_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid)
        else $error("R7 response dropped before bready");

    a_r8_rvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)))
        else $error("R8 read data not held");

    a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && push_req && !pop) |=> fifo_full)
        else $error("R5 full queue changed on dropped push");

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_tx |=> fifo_empty)
        else $error("R10 queue not empty after flush");

endmodule

bind lite_serial_tx lst_checker #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .awvalid    (awvalid),
    .wvalid     (wvalid),
    .awready    (awready),
    .wready     (wready),
    .bvalid     (bvalid),
    .bready     (bready),
    .arready    (arready),
    .rvalid     (rvalid),
    .rready     (rready),
    .rdata      (rdata),
    .tx         (tx),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .push_req   (push_req),
    .pop        (pop),
    .flush_tx   (flush_tx)
);

// File: tb/lite_serial_tx_tb_top.sv
`timescale 1ns / 1ps
module lite_serial_tx_tb_top;

    localparam int BAUD   = 115_200;
    localparam int CLK_HZ = BAUD * 64;
    localparam int DIV    = (CLK_HZ + BAUD / 2) / BAUD;
    localparam int DEPTH  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  awaddr = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b0;
    logic [3:0]  araddr = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rvalid;
    logic        rready = 1'b0;
    logic        tx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] rx_q [64];
    int         rx_n = 0;
    int         frame_err = 0;

    always #4 clk = ~clk;

    lite_serial_tx #(
        .CLK_HZ (CLK_HZ),
        .BAUD   (BAUD),
        .DEPTH  (DEPTH)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .awaddr (awaddr), .awvalid (awvalid), .awready (awready),
        .wdata (wdata), .wstrb (wstrb), .wvalid (wvalid), .wready (wready),
        .bresp (bresp), .bvalid (bvalid), .bready (bready),
        .araddr (araddr), .arvalid (arvalid), .arready (arready),
        .rdata (rdata), .rresp (rresp), .rvalid (rvalid), .rready (rready),
        .tx (tx)
    );

    // Line receiver: samples mid-bit on falling clock edges.
    initial begin
        forever begin
            logic [7:0] b;
            @(negedge tx);
            repeat (DIV / 2) @(negedge clk);
            if (tx !== 1'b0) frame_err++;
            for (int i = 0; i < 8; i++) begin
                repeat (DIV) @(negedge clk);
                b[i] = tx;
            end
            repeat (DIV) @(negedge clk);
            if (tx !== 1'b1) frame_err++;
            if (rx_n < 64) rx_q[rx_n] = b;
            rx_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // order: 0 together, 1 address first, 2 data first
    task automatic axi_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int order, input int bdelay);
        int guard;
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s;
        if (order != 2) awvalid = 1'b1;
        if (order != 1) wvalid = 1'b1;
        if (order != 0) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(!awready && !wready, "R6", "ready with one valid", {awready, wready}, 0);
            end
            awvalid = 1'b1; wvalid = 1'b1;
        end
        guard = 0;
        while (!awready && guard < 20) begin @(negedge clk); guard++; end
        chk(awready && wready, "R6", "paired ready", {awready, wready}, 2'b11);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        chk(!awready, "R6", "ready single cycle", awready, 0);
        chk(bvalid && bresp == 2'b00, "R7", "response", {bvalid, bresp}, 3'b100);
        for (int i = 0; i < bdelay; i++) begin
            @(negedge clk);
            chk(bvalid, "R7", "bvalid held", bvalid, 1);
        end
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
    endtask

    task automatic axi_rd(input logic [3:0] a, input int rdelay, output logic [31:0] d);
        int guard;
        logic [31:0] first;
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        guard = 0;
        while (!arready && guard < 20) begin @(negedge clk); guard++; end
        @(negedge clk);
        arvalid = 1'b0;
        first = rdata;
        chk(rvalid && rresp == 2'b00, "R8", "read valid", {rvalid, rresp}, 3'b100);
        for (int i = 0; i < rdelay; i++) begin
            @(negedge clk);
            chk(rvalid && rdata == first, "R8", "read held", rdata, first);
        end
        d = rdata;
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic wait_rx(input int n, input int limit);
        for (int i = 0; i < limit && rx_n < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(tx === 1'b1 && !bvalid && !rvalid && !awready && !arready, "R1", "reset outputs",
            {tx, bvalid, rvalid, awready, arready}, 5'b10000);
        axi_rd(4'h8, 0, d);
        chk(d == 32'h4, "R1", "status after reset", d, 32'h4);
    endtask

    task automatic t_single_frame();
        rx_n = 0; frame_err = 0;
        axi_wr(4'h4, 32'hFFFF_FFA5 & 32'h0000_01A5, 4'hF, 0, 0);
        wait_rx(1, DIV * 14);
        chk(rx_n == 1 && rx_q[0] == 8'hA5, "R3", "low byte sent", rx_q[0], 8'hA5);
        chk(frame_err == 0, "R2", "start/stop bits", frame_err, 0);
    endtask

    task automatic t_orders();
        logic [31:0] d;
        rx_n = 0;
        axi_wr(4'h4, 32'h3C, 4'h1, 1, 4);
        axi_wr(4'h4, 32'hC3, 4'h1, 2, 2);
        axi_rd(4'h0, 3, d);
        chk(d == 0, "R12", "read of 0x0", d, 0);
        wait_rx(2, DIV * 30);
        chk(rx_n == 2 && rx_q[0] == 8'h3C && rx_q[1] == 8'hC3, "R4", "order kept",
            {rx_q[0], rx_q[1]}, 16'h3CC3);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        int ok;
        rx_n = 0;
        for (int i = 0; i < 20; i++) axi_wr(4'h4, i, 4'h1, 0, 0);
        axi_rd(4'h8, 0, d);
        chk(d == 32'h8, "R9", "status full", d, 32'h8);
        wait_rx(DEPTH + 2, DIV * 11 * (DEPTH + 3));
        chk(rx_n == DEPTH + 1, "R5", "bytes kept on overflow", rx_n, DEPTH + 1);
        ok = 1;
        for (int i = 0; i <= DEPTH; i++) if (rx_q[i] != 8'(i)) ok = 0;
        chk(ok == 1, "R4", "overflow contents", ok, 1);
        axi_rd(4'h8, 0, d);
        chk(d == 32'h4, "R9", "status empty after drain", d, 32'h4);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        rx_n = 0; frame_err = 0;
        for (int i = 0; i < 5; i++) axi_wr(4'h4, 32'h11 + i, 4'h1, 0, 0);
        axi_wr(4'hC, 32'h1, 4'h1, 0, 0);
        axi_rd(4'h8, 0, d);
        chk(d == 32'h4, "R10", "empty after flush", d, 32'h4);
        axi_wr(4'h4, 32'h77, 4'h1, 0, 0);
        wait_rx(3, DIV * 40);
        chk(rx_n == 2 && rx_q[0] == 8'h11 && rx_q[1] == 8'h77, "R10", "in-flight byte kept",
            {rx_n[7:0], rx_q[0], rx_q[1]}, 24'h021177);
        chk(frame_err == 0, "R10", "in-flight frame intact", frame_err, 0);
    endtask

    task automatic t_cmd_bit1();
        logic [31:0] d;
        rx_n = 0;
        for (int i = 0; i < 3; i++) axi_wr(4'h4, 32'h60 + i, 4'h1, 0, 0);
        axi_wr(4'hC, 32'h2, 4'h1, 0, 0);
        axi_rd(4'h8, 0, d);
        chk(d == 32'h0, "R11", "queue kept after bit1", d, 0);
        axi_rd(4'hC, 0, d);
        chk(d == 32'h0, "R11", "command reads zero", d, 0);
        wait_rx(4, DIV * 50);
        chk(rx_n == 3 && rx_q[2] == 8'h62, "R11", "bytes still sent", {rx_n[7:0], rx_q[2]}, 16'h0362);
    endtask

    task automatic t_ignored_writes();
        logic [31:0] d;
        rx_n = 0;
        axi_wr(4'h4, 32'h5A, 4'hE, 0, 0);
        axi_wr(4'h0, 32'h99, 4'hF, 0, 0);
        axi_wr(4'h8, 32'hFF, 4'hF, 0, 0);
        axi_rd(4'h8, 0, d);
        chk(d == 32'h4, "R3", "no push without strobe 0", d, 32'h4);
        wait_rx(1, DIV * 24);
        chk(rx_n == 0, "R12", "no frames from ignored writes", rx_n, 0);
        chk(tx === 1'b1, "R2", "line idle high", tx, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_frame();
        t_orders();
        t_overflow();
        t_flush();
        t_cmd_bit1();
        t_ignored_writes();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule